// File: doc/BRIEF.md
# Serial Flash Continuous / Page Read Sequencer

This block is the read path behind the serial port of a flash array that holds 4096 pages of 528 bytes. The host selects the block with an active-low select, then presents one bit per serial clock tick: an 8-bit read command, a 24-bit start address, and 32 latency bits whose values are ignored. From the tick that completes the latency phase onward, the block puts one data bit per tick on its serial output, most significant bit first. It takes the bytes from an internal address that advances by itself.

Two read commands exist. The streaming form runs across page boundaries and wraps from the end of the array back to its start. The single-page form stays inside the chosen page and returns to its first byte after its last one. The page size is not a power of two, so the byte counter rolls over at 528. The next byte is fetched from the array model while the current one is shifting out, so no gap appears at any boundary.

The serial clock is presented as a one-system-clock strobe, `sck_tick`. Consecutive strobes must be at least four system clocks apart. The array model is a synchronous read port whose content is computed from the address.

Top module: `flash_rd_seq`

## Requirements
- R1: After reset, and whenever `cs_n` is high, `so_oe` is 0 and `so` is 0.
- R2: The first 8 ticks after `cs_n` falls give the command, MSB first. 8'h68 and 8'hE8 select streaming read. 8'h52 and 8'hD2 select single-page read. Any other command leaves `so_oe` at 0 until `cs_n` rises again.
- R3: The next 24 ticks give the address, MSB first: 2 ignored bits, then a 12-bit page number, then a 10-bit byte offset.
- R4: The 32 ticks after the address produce no output: `so_oe` stays 0 through the 63rd tick of the select. Once the 64th tick has registered, `so_oe` is 1 and `so` carries bit 7 of the first byte.
- R5: Each later tick moves `so` to the next lower bit. After 8 ticks the next byte follows at once from the next address.
- R6: In streaming read, the byte after offset 527 is offset 0 of the next page.
- R7: In streaming read, the byte after page 4095, offset 527 is page 0, offset 0.
- R8: In single-page read, the byte after offset 527 is offset 0 of the same page.
- R9: A start offset of 528 or more is reduced by 528, so 1000 starts at 472 and 1023 starts at 495.
- R10: A rise of `cs_n` drops `so_oe` in the same cycle and abandons any partly sent byte. The next select decodes a new command from its first tick.
- R11: The array model holds the byte (16 × page + offset) mod 256 at each address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; a rise ends the transfer |
| sck_tick | input | 1 | One-cycle strobe per serial clock |
| si | input | 1 | Serial command/address input, sampled on `sck_tick` |
| so | output | 1 | Serial data output |
| so_oe | output | 1 | Output enable for `so` (0 = high impedance) |

## Verification
Assertions check on every cycle that:
- the byte offset never leaves 0..527;
- an advance from the last offset lands on offset 0, on the following page, on page 0 after the last page, or on the same page, as the command requires;
- the shifter moves one bit per data tick;
- a high select returns the decoder to its command phase.

Only the bench's scenarios can show the complete serial protocol:
- the 64-tick latency before output;
- the exact byte values across page crossings, the array wrap and in-page wrap;
- the reduction of oversized offsets;
- the silence on unknown commands;
- a clean restart after an aborted read.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam logic [7:0] OPC_STREAM_A = 8'h68;
  localparam logic [7:0] OPC_STREAM_B = 8'hE8;
  localparam logic [7:0] OPC_PAGE_A   = 8'h52;
  localparam logic [7:0] OPC_PAGE_B   = 8'hD2;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WAIT,
    PH_DATA,
    PH_SKIP
  } phase_e;

  function automatic logic is_stream(input logic [7:0] op);
    return (op == OPC_STREAM_A) || (op == OPC_STREAM_B);
  endfunction

  function automatic logic is_page(input logic [7:0] op);
    return (op == OPC_PAGE_A) || (op == OPC_PAGE_B);
  endfunction
endpackage

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import flash_rd_pkg::*;
#(
  parameter int PAGE_W   = 12,
  parameter int BYTE_W   = 10,
  parameter int RSV_W    = 2,
  parameter int OPC_BITS = 8,
  parameter int WAIT_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_tick,
  input  logic              si,
  output logic              addr_load,
  output logic [PAGE_W-1:0] ld_page,
  output logic [BYTE_W-1:0] ld_off,
  output logic              mode_stream,
  output logic              data_start,
  output logic              data_tick,
  output logic              in_data
);
  localparam int ADDR_BITS = RSV_W + PAGE_W + BYTE_W;
  localparam int WORD_W    = PAGE_W + BYTE_W;
  localparam int SREG_W    = WORD_W - 1;
  localparam int PH_MAX    = (ADDR_BITS > WAIT_BITS) ? ADDR_BITS : WAIT_BITS;
  localparam int CNT_W     = $clog2(PH_MAX);

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SREG_W-1:0] sreg_q, sreg_d;
  logic              mode_q, mode_d;
  logic [WORD_W-1:0] word;
  logic              tick;
  logic              upd_en;

  assign tick   = sck_tick & ~cs_n;
  assign upd_en = cs_n | tick;
  assign word   = {sreg_q, si};

  always_comb begin
    ph_d       = ph_q;
    cnt_d      = cnt_q;
    sreg_d     = sreg_q;
    mode_d     = mode_q;
    addr_load  = 1'b0;
    data_start = 1'b0;
    if (cs_n) begin
      ph_d  = PH_CMD;
      cnt_d = '0;
    end else if (tick) begin
      sreg_d = word[SREG_W-1:0];
      unique case (ph_q)
        PH_CMD: begin
          if (cnt_q == CNT_W'(OPC_BITS - 1)) begin
            cnt_d = '0;
            if (is_stream(word[7:0])) begin
              mode_d = 1'b1;
              ph_d   = PH_ADDR;
            end else if (is_page(word[7:0])) begin
              mode_d = 1'b0;
              ph_d   = PH_ADDR;
            end else begin
              ph_d = PH_SKIP;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_ADDR: begin
          if (cnt_q == CNT_W'(ADDR_BITS - 1)) begin
            addr_load = 1'b1;
            cnt_d     = '0;
            ph_d      = PH_WAIT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_WAIT: begin
          if (cnt_q == CNT_W'(WAIT_BITS - 1)) begin
            data_start = 1'b1;
            cnt_d      = '0;
            ph_d       = PH_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_CMD;
      cnt_q  <= '0;
      sreg_q <= '0;
      mode_q <= 1'b0;
    end else if (upd_en) begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sreg_q <= sreg_d;
      mode_q <= mode_d;
    end
  end

  assign ld_off      = word[BYTE_W-1:0];
  assign ld_page     = word[BYTE_W +: PAGE_W];
  assign mode_stream = mode_q;
  assign in_data     = (ph_q == PH_DATA);
  assign data_tick   = tick & in_data;

  p_deselect_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (ph_q == PH_CMD) && (cnt_q == '0));

  p_addr_then_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> (ph_q == PH_WAIT) && (cnt_q == '0));
endmodule

// File: rtl/frs_addr.sv
module frs_addr #(
  parameter int PAGE_W     = 12,
  parameter int BYTE_W     = 10,
  parameter int PAGE_BYTES = 528
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [BYTE_W-1:0] ld_off,
  input  logic              mode_stream,
  input  logic              adv,
  output logic [PAGE_W-1:0] page_q,
  output logic [BYTE_W-1:0] byte_q
);
  localparam logic [BYTE_W-1:0] PAGE_LEN  = BYTE_W'(PAGE_BYTES);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PAGE_BYTES - 1);
  localparam logic [PAGE_W-1:0] LAST_PAGE = '1;

  logic [PAGE_W-1:0] page_d;
  logic [BYTE_W-1:0] byte_d;
  logic              en;

  assign en = load | adv;

  always_comb begin
    page_d = page_q;
    byte_d = byte_q;
    if (load) begin
      page_d = ld_page;
      byte_d = (ld_off >= PAGE_LEN) ? ld_off - PAGE_LEN : ld_off;
    end else if (adv) begin
      if (byte_q == LAST_BYTE) begin
        byte_d = '0;
        if (mode_stream) begin
          page_d = (page_q == LAST_PAGE) ? '0 : page_q + 1'b1;
        end
      end else begin
        byte_d = byte_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      byte_q <= '0;
    end else if (en) begin
      page_q <= page_d;
      byte_q <= byte_d;
    end
  end

  p_offset_in_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_q <= LAST_BYTE);

  p_next_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && mode_stream && byte_q == LAST_BYTE && page_q != LAST_PAGE)
    |=> (byte_q == '0) && (page_q == $past(page_q) + 1'b1));

  p_array_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && mode_stream && byte_q == LAST_BYTE && page_q == LAST_PAGE)
    |=> (byte_q == '0) && (page_q == '0));

  p_same_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !mode_stream) |=> $stable(page_q));
endmodule

// File: rtl/frs_array.sv
module frs_array #(
  parameter int PAGE_W = 12,
  parameter int BYTE_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [PAGE_W-1:0] page,
  input  logic [BYTE_W-1:0] offset,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int SUM_W = PAGE_W + 4 + BYTE_W;

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = DATA_W'(({4'b0, page, 4'b0000} + SUM_W'(offset)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/frs_shift.sv
module frs_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dtick,
  input  logic [DATA_W-1:0] rdata,
  output logic              so_bit,
  output logic              adv
);
  localparam int BC_W = $clog2(DATA_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic              reload;
  logic              en;

  assign reload = start | (dtick & (bc_q == LAST_BIT));
  assign en     = start | dtick;
  assign adv    = reload;

  always_comb begin
    sh_d = sh_q;
    bc_d = bc_q;
    if (reload) begin
      sh_d = rdata;
      bc_d = '0;
    end else if (dtick) begin
      sh_d = {sh_q[DATA_W-2:0], 1'b0};
      bc_d = bc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      bc_q <= '0;
    end else if (en) begin
      sh_q <= sh_d;
      bc_q <= bc_d;
    end
  end

  assign so_bit = sh_q[DATA_W-1];

  p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dtick && !start && bc_q != LAST_BIT)
    |=> (sh_q[DATA_W-1] == $past(sh_q[DATA_W-2])) && (bc_q == $past(bc_q) + 1'b1));

  p_byte_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dtick && bc_q == LAST_BIT) |=> (bc_q == '0));
endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq #(
  parameter int PAGE_W     = 12,
  parameter int BYTE_W     = 10,
  parameter int PAGE_BYTES = 528,
  parameter int RSV_W      = 2,
  parameter int WAIT_BITS  = 32,
  parameter int DATA_W     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck_tick,
  input  logic si,
  output logic so,
  output logic so_oe
);
  logic              addr_load;
  logic [PAGE_W-1:0] ld_page;
  logic [BYTE_W-1:0] ld_off;
  logic              mode_stream;
  logic              data_start;
  logic              data_tick;
  logic              in_data;
  logic              adv;
  logic [PAGE_W-1:0] cur_page;
  logic [BYTE_W-1:0] cur_off;
  logic [DATA_W-1:0] rdata;
  logic              so_bit;

  frs_ctrl #(
    .PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .RSV_W(RSV_W),
    .OPC_BITS(8), .WAIT_BITS(WAIT_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_tick(sck_tick), .si(si),
    .addr_load(addr_load), .ld_page(ld_page), .ld_off(ld_off),
    .mode_stream(mode_stream), .data_start(data_start),
    .data_tick(data_tick), .in_data(in_data)
  );

  frs_addr #(
    .PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .ld_page(ld_page),
    .ld_off(ld_off), .mode_stream(mode_stream), .adv(adv),
    .page_q(cur_page), .byte_q(cur_off)
  );

  frs_array #(
    .PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .rd_en(~cs_n), .page(cur_page),
    .offset(cur_off), .rdata_q(rdata)
  );

  frs_shift #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .start(data_start), .dtick(data_tick),
    .rdata(rdata), .so_bit(so_bit), .adv(adv)
  );

  assign so_oe = in_data & ~cs_n;
  assign so    = so_oe & so_bit;

  p_silent_unless_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_data) |-> (so == 1'b0));
endmodule

// File: tb/flash_rd_seq_tb_top.sv
module flash_rd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_LEN   = 528;
  localparam int NPAGES     = 4096;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n;
  logic sck_tick;
  logic si;
  logic so;
  logic so_oe;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic [7:0] exp_q[$];
  string      tag = "R5";
  logic       samp_req = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_rd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_tick(sck_tick),
    .si(si), .so(so), .so_oe(so_oe)
  );

  function automatic logic [7:0] model_byte(input int p, input int b);
    return 8'((16 * p + b) % 256);
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: assembles serial bits and pops expected bytes.
  logic [7:0] m_sh = '0;
  int         m_cnt = 0;
  logic       m_oe_bad = 1'b0;
  always @(negedge clk) begin
    #1;
    if (cs_n) begin
      m_cnt    = 0;
      m_oe_bad = 1'b0;
    end else if (samp_req) begin
      if (so_oe !== 1'b1) m_oe_bad = 1'b1;
      m_sh = {m_sh[6:0], so};
      m_cnt++;
      if (m_cnt == 8) begin
        m_cnt = 0;
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL %s actual=%0h expected=<none>", tag, m_sh);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (m_sh !== e || m_oe_bad) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h oe_bad=%0b",
                     tag, m_sh, e, m_oe_bad);
          end
        end
        m_oe_bad = 1'b0;
      end
    end
  end

  task automatic tick(input logic b, input logic samp);
    @(negedge clk);
    si = b;
    sck_tick = 1'b1;
    @(negedge clk);
    sck_tick = 1'b0;
    samp_req = samp;
    @(negedge clk);
    samp_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_header(input logic [7:0] op, input logic [1:0] rsv,
                             input int page, input int off);
    logic [23:0] a;
    a = {rsv, 12'(page), 10'(off)};
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 7; i >= 0; i--) tick(op[i], 1'b0);
    for (int i = 23; i >= 0; i--) tick(a[i], 1'b0);
    for (int i = 0; i < 31; i++) tick(1'b0, 1'b0);
  endtask

  task automatic deselect(input string req);
    @(negedge clk);
    cs_n = 1'b1;
    #1;
    check(req, {31'b0, so_oe}, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_read(input string req, input logic [7:0] op,
                          input logic stream, input logic [1:0] rsv,
                          input int page, input int off, input int nbytes);
    int p;
    int b;
    tag = req;
    send_header(op, rsv, page, off);
    check({req, " R4 latency"}, {31'b0, so_oe}, 32'd0);
    p = page;
    b = (off >= PAGE_LEN) ? off - PAGE_LEN : off;
    for (int k = 0; k < nbytes; k++) begin
      exp_q.push_back(model_byte(p, b));
      if (b == PAGE_LEN - 1) begin
        b = 0;
        if (stream) p = (p == NPAGES - 1) ? 0 : p + 1;
      end else begin
        b++;
      end
    end
    for (int i = 0; i < 8 * nbytes; i++) tick(1'b0, 1'b1);
    check({req, " queue drained"}, exp_q.size(), 32'd0);
    deselect("R10");
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=%0d expected<200000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic oe_seen;
    rst_n = 1'b0;
    cs_n = 1'b1;
    sck_tick = 1'b0;
    si = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset / deselected state
    check("R1", {30'b0, so_oe, so}, 32'd0);

    // R2 R3 R5 R11: streaming read from page 0, offset 0
    run_read("R11", 8'h68, 1'b1, 2'b00, 0, 0, 3);
    // R6: page crossing in streaming mode (alternate opcode, reserved bits set for R3)
    run_read("R6", 8'hE8, 1'b1, 2'b11, 5, 525, 6);
    // R7: end of array wraps to page 0
    run_read("R7", 8'h68, 1'b1, 2'b10, 4095, 526, 4);
    // R8: in-page wrap
    run_read("R8", 8'h52, 1'b0, 2'b01, 100, 526, 4);
    run_read("R8", 8'hD2, 1'b0, 2'b00, 4095, 527, 3);
    // R9: oversized offsets
    run_read("R9", 8'hD2, 1'b0, 2'b00, 9, 1000, 3);
    run_read("R9", 8'hE8, 1'b1, 2'b00, 3, 1023, 3);

    // R2: unknown command stays silent
    @(negedge clk);
    cs_n = 1'b0;
    oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) tick(1'(8'h0B >> i), 1'b0);
    for (int i = 0; i < 80; i++) begin
      tick(1'b1, 1'b0);
      if (so_oe !== 1'b0) oe_seen = 1'b1;
    end
    check("R2 unknown opcode", {31'b0, oe_seen}, 32'd0);
    deselect("R10");

    // R10: abort in the middle of a byte, then a fresh command
    send_header(8'h68, 2'b00, 7, 3);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0);
    check("R10 active before abort", {31'b0, so_oe}, 32'd1);
    deselect("R10");
    run_read("R10", 8'h52, 1'b0, 2'b00, 12, 10, 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule